// File: doc/BRIEF.md
# Event-Cleared 16-bit Timer/Counter

This peripheral keeps a 16-bit up-count that advances on the core clock or on rising edges of an external clock pin, through a selectable divide-by-1/2/4/8 prescaler. When the count rolls over from all ones to zero it raises a sticky overflow flag, and an interrupt request goes out while the matching enable bit is also set. Software reaches the control, status and count registers through a byte-wide bus with a combinational read port.

A compare unit elsewhere on the chip can pulse `evt_trig` to clear the count. That clear never counts as an overflow. A software write to the count in the same cycle wins over it. Because of these two rules, the compare value acts as the period of the timer. When the external clock is used without the synchronizer, the trigger is ignored.

Top module: `evt_timer16`

## Requirements
- R1: With the timer running and no write or trigger, each prescaler output step adds one to the count, and the count goes from 0xFFFF to 0x0000.
- R2: The roll-over from 0xFFFF to 0x0000 sets the overflow flag (status register, address 3, bit 0). The flag stays 1 until software writes bit 0 of the status register. A status write loads bit 0 into the flag and bit 1 into the interrupt enable.
- R3: `irq` is 1 exactly while the overflow flag and the interrupt enable (status bit 1) are both 1, and it follows a status write on the next clock edge.
- R4: An `evt_trig` cycle clears the count to 0x0000 at the next edge, whether the timer-on bit is set or not. This holds with the internal clock or with the synchronized external clock. The same cycle also clears the prescaler.
- R5: A count clear caused by `evt_trig` never sets the overflow flag, including when it lands on the cycle where 0xFFFF would have rolled over.
- R6: A count write (address 1, or address 2 with 16-bit mode off) in the same cycle as `evt_trig` loads the written value, and the trigger has no effect.
- R7: With control bit 1 = 1 (external clock) and control bit 2 = 1 (synchronizer bypassed), `evt_trig` leaves the count unchanged.
- R8: Control bits 5:4 select the prescale ratio: 00, 01, 10 and 11 give 1, 2, 4 and 8. Any count write clears the prescaler.
- R9: The register map is: address 0 control, address 1 count low byte, address 2 count high byte, address 3 status. In the control register, bit 0 = timer on, bit 1 = external clock, bit 2 = synchronizer bypass, bit 7 = 16-bit access, and bits 6 and 3 are stored and read back. With bit 0 = 0 the count holds.
- R10: With control bit 7 = 1, a low-byte read latches the high byte, and the following high-byte read returns that latched value. A high-byte write only fills a buffer. The next low-byte write loads both bytes together.
- R11: With control bit 7 = 0, each byte reads and writes the live count directly.
- R12: In external mode the count advances once per rising edge of `ext_clk_in`. With the synchronizer, that edge first passes a two-flop synchronizer. With the synchronizer bypassed, it passes a one-flop edge detector.
- R13: After `rst_n` the control register, the status register and the count all read 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the high-byte latch) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ext_clk_in | input | 1 | External count clock |
| evt_trig | input | 1 | Compare-match clear pulse |
| irq | output | 1 | Overflow interrupt request |

## Verification
Register writes, trigger clears and prescaler steps all act at the edge that ends the cycle in which they are presented. The bench drives every stimulus at a falling edge and samples one nanosecond after the relevant rising edge. It reads `bus_rdata` before the next rising edge, so a count sampled n edges after the timer-on write must equal n divided by the ratio, rounded down. External-clock pulses are held for four cycles on each level, which covers the three-register latency of the synchronized path. Reads are counted as consuming one edge, so later expectations such as the latched high byte and the sticky flag are taken at that edge.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_CNT_LO = 2'd1;
    localparam logic [1:0] A_CNT_HI = 2'd2;
    localparam logic [1:0] A_STAT   = 2'd3;

    localparam int C_ON     = 0;
    localparam int C_EXT    = 1;
    localparam int C_NOSYNC = 2;
    localparam int C_PS_LO  = 4;
    localparam int C_PS_HI  = 5;
    localparam int C_RW16   = 7;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] hold_rd;
        logic [BYTE_W-1:0] hold_wr;
        logic              flag;
        logic              en;
    } tmr_state_t;
endpackage

// File: rtl/evt_timer16_clksrc.sv
module evt_timer16_clksrc #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic use_ext,
    input  logic sync_off,
    output logic evt
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;
    logic sync_edge, async_edge;

    always_comb begin
        chain_d    = {chain_q[CHAIN_W-2:0], ext_in};
        sync_edge  = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        async_edge = ext_in & ~chain_q[0];
        if (!use_ext)     evt = 1'b1;
        else if (sync_off) evt = async_edge;
        else              evt = sync_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/evt_timer16_prescale.sv
module evt_timer16_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             adv
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] pc_d, pc_q, term;

    always_comb begin
        term = DIV_W'((32'd1 << sel) - 32'd1);
        adv  = tick & (pc_q >= term);
        pc_d = pc_q;
        if (clr)       pc_d = '0;
        else if (adv)  pc_d = '0;
        else if (tick) pc_d = pc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PS_SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk_in,
    input  logic              evt_trig,
    output logic              irq
);
    tmr_state_t st_d, st_q;

    logic rw16, use_ext, sync_off, run, async_md;
    logic [PS_SEL_W-1:0] ps_sel;
    logic wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;
    logic cnt_wr, trig_clr, src_evt, tick, adv, wrap;

    assign rw16     = st_q.ctrl[C_RW16];
    assign use_ext  = st_q.ctrl[C_EXT];
    assign sync_off = st_q.ctrl[C_NOSYNC];
    assign run      = st_q.ctrl[C_ON];
    assign ps_sel   = st_q.ctrl[C_PS_LO +: PS_SEL_W];
    assign async_md = use_ext & sync_off;

    assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
    assign wr_lo    = bus_wr & (bus_addr == A_CNT_LO);
    assign wr_hi    = bus_wr & (bus_addr == A_CNT_HI);
    assign wr_stat  = bus_wr & (bus_addr == A_STAT);
    assign rd_lo    = bus_rd & (bus_addr == A_CNT_LO);

    assign cnt_wr   = wr_lo | (wr_hi & ~rw16);
    assign trig_clr = evt_trig & ~async_md;
    assign tick     = run & src_evt;

    evt_timer16_clksrc #(.SYNC_STAGES(SYNC_STAGES)) clksrc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_clk_in),
        .use_ext  (use_ext),
        .sync_off (sync_off),
        .evt      (src_evt)
    );

    evt_timer16_prescale #(.SEL_W(PS_SEL_W)) prescale_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (cnt_wr | trig_clr),
        .sel   (ps_sel),
        .adv   (adv)
    );

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;

        if (wr_ctrl)        st_d.ctrl    = bus_wdata;
        if (wr_hi && rw16)  st_d.hold_wr = bus_wdata;
        if (rd_lo && rw16)  st_d.hold_rd = st_q.cnt[CNT_W-1:BYTE_W];

        // write beats trigger, trigger beats counting
        if (wr_lo) begin
            if (rw16) st_d.cnt = {st_q.hold_wr, bus_wdata};
            else      st_d.cnt = {st_q.cnt[CNT_W-1:BYTE_W], bus_wdata};
        end else if (wr_hi && !rw16) begin
            st_d.cnt = {bus_wdata, st_q.cnt[BYTE_W-1:0]};
        end else if (trig_clr) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = (st_q.cnt == '1);
        end

        if (wr_stat) begin
            st_d.flag = bus_wdata[0];
            st_d.en   = bus_wdata[1];
        end
        if (wrap) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = st_q.ctrl;
            A_CNT_LO: bus_rdata = st_q.cnt[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = rw16 ? st_q.hold_rd : st_q.cnt[CNT_W-1:BYTE_W];
            default:  bus_rdata = {{(BYTE_W-2){1'b0}}, st_q.en, st_q.flag};
        endcase
    end

    assign irq = st_q.flag & st_q.en;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk
    import evt_timer16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              evt_trig,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic              flag_q
);
    logic cnt_wr, stat_wr, async_md;
    assign cnt_wr   = bus_wr & ((bus_addr == A_CNT_LO) |
                                ((bus_addr == A_CNT_HI) & ~ctrl_q[C_RW16]));
    assign stat_wr  = bus_wr & (bus_addr == A_STAT);
    assign async_md = ctrl_q[C_EXT] & ctrl_q[C_NOSYNC];

    a_r1_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !cnt_wr && !evt_trig) |=> (cnt_q == '1 || (cnt_q == '0 && flag_q)));

    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !stat_wr) |=> flag_q);

    a_r4_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_trig && !async_md && !cnt_wr) |=> (cnt_q == '0));

    a_r5_trig_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_trig && !async_md && !stat_wr && !flag_q) |=> !flag_q);

    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNT_LO && evt_trig) |=> (cnt_q[BYTE_W-1:0] == $past(bus_wdata)));

    a_r7_async_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_trig && async_md && !cnt_wr && !ctrl_q[C_ON]) |=> $stable(cnt_q));

    a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[C_ON] && !cnt_wr && !evt_trig) |=> $stable(cnt_q));
endmodule

bind evt_timer16 evt_timer16_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_trig  (evt_trig),
    .cnt_q     (st_q.cnt),
    .ctrl_q    (st_q.ctrl),
    .flag_q    (st_q.flag)
);

// File: tb/evt_timer16_tb_top.sv
module evt_timer16_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk_in = 1'b0, evt_trig = 1'b0;
    logic       irq;

    int n_chk = 0, n_bad = 0;
    logic [7:0] rd;

    localparam logic [1:0] CTRL = 2'd0, LO = 2'd1, HI = 2'd2, STAT = 2'd3;

    // {prescale select, edges after start, expected low byte}
    localparam logic [23:0] VEC [6] = '{
        24'h00_05_05, 24'h01_05_02, 24'h02_09_02,
        24'h03_11_02, 24'h03_07_00, 24'h02_04_01
    };

    always #5 clk = ~clk;

    evt_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_in(ext_clk_in), .evt_trig(evt_trig), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rdr(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic trig_pulse();
        evt_trig = 1'b1;
        @(posedge clk); #1;
        evt_trig = 1'b0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; repeat (4) @(posedge clk); #1;
            ext_clk_in = 1'b0; repeat (4) @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R13 reset state
        rdr(CTRL, rd); check("R13 ctrl", rd, 8'h00);
        rdr(STAT, rd); check("R13 status", rd, 8'h00);
        rdr(LO, rd);   check("R13 count", rd, 8'h00);
        check("R13 irq", irq, 1'b0);

        // R8 prescale table
        for (int v = 0; v < 6; v++) begin
            wr(CTRL, 8'h00); wr(HI, 8'h00); wr(LO, 8'h00);
            wr(CTRL, {2'b00, VEC[v][17:16], 4'b0001});
            repeat (int'(VEC[v][15:8])) @(posedge clk);
            #1;
            rdr(LO, rd);
            check($sformatf("R8 ratio sel %0d", VEC[v][17:16]), rd, VEC[v][7:0]);
        end
        wr(CTRL, 8'h00);

        // R8 prescaler cleared by count write (ratio 8)
        wr(LO, 8'h00); wr(CTRL, 8'h31);
        repeat (5) @(posedge clk); #1;
        wr(LO, 8'h10);
        repeat (7) @(posedge clk); #1;
        rdr(LO, rd); check("R8 prescaler clear", rd, 8'h10);
        wr(CTRL, 8'h00);

        // R9 control readback and hold while off
        wr(CTRL, 8'h48);
        rdr(CTRL, rd); check("R9 ctrl readback", rd, 8'h48);
        wr(CTRL, 8'h00); wr(HI, 8'h00); wr(LO, 8'h77);
        repeat (10) @(posedge clk); #1;
        rdr(LO, rd); check("R9 off holds", rd, 8'h77);

        // R11 direct byte access
        wr(HI, 8'hAB);
        rdr(HI, rd); check("R11 direct high", rd, 8'hAB);
        rdr(LO, rd); check("R11 low untouched", rd, 8'h77);

        // R10 16-bit latched access
        wr(CTRL, 8'h80); wr(HI, 8'h12); wr(LO, 8'h34);
        rdr(LO, rd); check("R10 low read", rd, 8'h34);
        wr(HI, 8'h56);
        rdr(HI, rd); check("R10 latched high", rd, 8'h12);
        wr(LO, 8'h78);
        rdr(LO, rd); check("R10 pair low", rd, 8'h78);
        rdr(HI, rd); check("R10 pair high", rd, 8'h56);

        // R1 R2 R3 wraparound in 16-bit mode
        wr(HI, 8'hFF); wr(LO, 8'hFE); wr(STAT, 8'h00);
        wr(CTRL, 8'h81);
        @(posedge clk); #1;
        rdr(LO, rd); check("R1 reach 0xFFFF low", rd, 8'hFF);
        rdr(HI, rd); check("R1 reach 0xFFFF high", rd, 8'hFF);
        rdr(STAT, rd); check("R2 flag on wrap", rd, 8'h01);
        check("R3 irq gated off", irq, 1'b0);
        wr(CTRL, 8'h80);
        repeat (4) @(posedge clk); #1;
        rdr(STAT, rd); check("R2 flag sticky", rd, 8'h01);
        wr(STAT, 8'h03); check("R3 irq raised", irq, 1'b1);
        wr(STAT, 8'h02); check("R3 irq dropped", irq, 1'b0);
        rdr(STAT, rd); check("R2 flag cleared", rd, 8'h02);
        wr(STAT, 8'h00);

        // R4 R5 trigger at the would-be wrap
        wr(CTRL, 8'h00); wr(HI, 8'hFF); wr(LO, 8'hFF);
        wr(CTRL, 8'h01);
        trig_pulse();
        rdr(LO, rd); check("R4 trigger clears", rd, 8'h00);
        rdr(STAT, rd); check("R5 no flag from trigger", rd, 8'h00);
        wr(CTRL, 8'h00);
        rdr(HI, rd); check("R4 high cleared", rd, 8'h00);

        // R6 write collides with trigger
        wr(HI, 8'h12); wr(LO, 8'h34);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = LO; bus_wdata = 8'h55; evt_trig = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; evt_trig = 1'b0;
        rdr(LO, rd); check("R6 write wins low", rd, 8'h55);
        rdr(HI, rd); check("R6 write wins high", rd, 8'h12);

        // R4 trigger in synchronized counter mode
        wr(LO, 8'h42); wr(CTRL, 8'h03);
        trig_pulse();
        rdr(LO, rd); check("R4 sync counter clear", rd, 8'h00);

        // R7 trigger ignored in async mode
        wr(CTRL, 8'h00); wr(LO, 8'h42); wr(CTRL, 8'h07);
        trig_pulse();
        rdr(LO, rd); check("R7 async ignores trigger", rd, 8'h42);

        // R12 external edge counting
        wr(CTRL, 8'h00); wr(LO, 8'h00); wr(CTRL, 8'h03);
        ext_pulses(3);
        rdr(LO, rd); check("R12 sync edges", rd, 8'h03);
        wr(CTRL, 8'h00); wr(LO, 8'h00); wr(CTRL, 8'h07);
        ext_pulses(3);
        rdr(LO, rd); check("R12 async edges", rd, 8'h03);
        wr(CTRL, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule